// File: doc/BRIEF.md
# CRC-8 Context Validation Tag Generator

This block produces a one-byte validation tag for a connection context. A connection identifier, a region code and a type code are packed into a 32-bit string. A parallel CRC-8 runs over all 32 bits of that string in a single step. The CRC is then folded into a tag byte whose top bit marks the context as valid.

A context store writes this tag beside a context to show that the context is live. The block also has a separate path for retiring a context. That path takes a tag that already exists and returns it with the valid marker cleared.

Both paths are registered. Each returns its result one clock after its input strobe, together with an output strobe.

Top module: `crc8tag_gen`

## Requirements
- R1: The CRC input string is {cid_i[23:0], region_i[3:0], type_i[3:0]}. The identifier sits in bits 31:8, the region in bits 7:4 and the type in bits 3:0.
- R2: The CRC uses the generator x^8 + x^2 + x + 1 and starts from the value 0xFF. It consumes all 32 string bits in one step, most significant bit first. Its value equals (0xFF·x^32 + string·x^8) mod the generator.
- R3: Bit 0 of crc_o is the XOR of string bits 0, 6, 7, 8, 12, 14, 16, 18, 19, 21, 23, 28, 30 and 31, inverted (the three seed terms, all ones, contribute a net 1).
- R4: tag_o[7] is 1, and tag_o[6:0] equals crc_o[6:0].
- R5: res_vld_o is high in the cycle after gen_vld_i is high, and low otherwise. crc_o and tag_o carry the new result in that same cycle.
- R6: While gen_vld_i is low, crc_o and tag_o keep their previous values.
- R7: One cycle after inv_vld_i, inv_vld_o is high and inv_tag_o equals tag_i with bit 7 cleared and bits 6:0 unchanged. inv_vld_o is low in cycles that do not follow an inv_vld_i.
- R8: The invalidate path and the generate path are independent. Strobes on both paths in the same cycle give both results, and an invalidate strobe leaves crc_o and tag_o unchanged.
- R9: While rst is high, and after it is released with no strobe, every output is zero.
- R10: The two aggregation region codes, 2 and 4, yield tags that follow R1 to R4 for any identifier and type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_vld_i | input | 1 | Strobe: compute a tag from cid_i, region_i, type_i |
| cid_i | input | 24 | Connection identifier |
| region_i | input | 4 | Region code |
| type_i | input | 4 | Type code |
| inv_vld_i | input | 1 | Strobe: invalidate tag_i |
| tag_i | input | 8 | Tag to be invalidated |
| res_vld_o | output | 1 | Generate result valid |
| crc_o | output | 8 | CRC-8 of the packed string |
| tag_o | output | 8 | Valid-marked tag |
| inv_vld_o | output | 1 | Invalidate result valid |
| inv_tag_o | output | 8 | Tag with the valid marker cleared |

## Verification
The assertions assume that reset is held for at least one clock edge before any strobe. They also assume that cid_i, region_i, type_i and tag_i are known whenever their strobe is high, because the checks look at the sampled inputs through $past. The bench changes inputs only on the falling edge and always asserts reset first. It drives defined values on every data input, even while the strobes are low. This keeps every input inside what the assertions rely on, while the hold and independence checks still see the data inputs changing.

// File: rtl/crc8tag_pkg.sv
package crc8tag_pkg;

    localparam int CID_W    = 24;
    localparam int REGION_W = 4;
    localparam int TYPE_W   = 4;
    localparam int STR_W    = CID_W + REGION_W + TYPE_W;
    localparam int CRC_W    = 8;

    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;   // x^8 + x^2 + x + 1
    localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;
    localparam logic [CRC_W-1:0] MARK_BIT = 8'h80;

    localparam logic [REGION_W-1:0] REGION_AGG_X = 4'd2;
    localparam logic [REGION_W-1:0] REGION_AGG_U = 4'd4;

    typedef struct packed {
        logic [CID_W-1:0]    cid;
        logic [REGION_W-1:0] region;
        logic [TYPE_W-1:0]   kind;
    } ctx_str_t;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] tag;
    } gen_res_t;

    // One shift step of the CRC register, data bit entering at the top
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                  input logic d);
        logic fb;
        fb = r[CRC_W-1] ^ d;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/crc8tag_pack.sv
module crc8tag_pack
    import crc8tag_pkg::*;
(
    input  logic [CID_W-1:0]    cid,
    input  logic [REGION_W-1:0] region,
    input  logic [TYPE_W-1:0]   kind,
    output ctx_str_t            str
);
    always_comb begin
        str.cid    = cid;
        str.region = region;
        str.kind   = kind;
    end
endmodule

// File: rtl/crc8tag_engine.sv
module crc8tag_engine
    import crc8tag_pkg::*;
(
    input  logic [STR_W-1:0] data,
    output logic [CRC_W-1:0] crc
);
    // Unrolled bit-serial recurrence: flattens to a pure XOR network
    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = CRC_SEED;
        for (int i = STR_W - 1; i >= 0; i--) begin
            acc = crc_step(acc, data[i]);
        end
        crc = acc;
    end
endmodule

// File: rtl/crc8tag_mark.sv
module crc8tag_mark
    import crc8tag_pkg::*;
(
    input  logic [CRC_W-1:0] crc,
    input  logic [CRC_W-1:0] tag_in,
    output logic [CRC_W-1:0] tag_valid,
    output logic [CRC_W-1:0] tag_cleared
);
    always_comb begin
        tag_valid   = crc | MARK_BIT;
        tag_cleared = tag_in & ~MARK_BIT;
    end
endmodule

// File: rtl/crc8tag_gen.sv
module crc8tag_gen
    import crc8tag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                gen_vld_i,
    input  logic [CID_W-1:0]    cid_i,
    input  logic [REGION_W-1:0] region_i,
    input  logic [TYPE_W-1:0]   type_i,
    input  logic                inv_vld_i,
    input  logic [CRC_W-1:0]    tag_i,
    output logic                res_vld_o,
    output logic [CRC_W-1:0]    crc_o,
    output logic [CRC_W-1:0]    tag_o,
    output logic                inv_vld_o,
    output logic [CRC_W-1:0]    inv_tag_o
);
    ctx_str_t         str_c;
    logic [CRC_W-1:0] crc_c;
    logic [CRC_W-1:0] tag_c;
    logic [CRC_W-1:0] inv_c;
    gen_res_t         res_q;
    logic             res_vld_q;
    logic             inv_vld_q;
    logic [CRC_W-1:0] inv_q;

    crc8tag_pack u_pack (
        .cid    (cid_i),
        .region (region_i),
        .kind   (type_i),
        .str    (str_c)
    );

    crc8tag_engine u_engine (
        .data (str_c),
        .crc  (crc_c)
    );

    crc8tag_mark u_mark (
        .crc         (crc_c),
        .tag_in      (tag_i),
        .tag_valid   (tag_c),
        .tag_cleared (inv_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            res_vld_q <= 1'b0;
            inv_vld_q <= 1'b0;
            inv_q     <= '0;
        end else begin
            res_vld_q <= gen_vld_i;
            if (gen_vld_i) begin
                res_q.crc <= crc_c;
                res_q.tag <= tag_c;
            end
            inv_vld_q <= inv_vld_i;
            if (inv_vld_i) begin
                inv_q <= inv_c;
            end
        end
    end

    assign res_vld_o = res_vld_q;
    assign crc_o     = res_q.crc;
    assign tag_o     = res_q.tag;
    assign inv_vld_o = inv_vld_q;
    assign inv_tag_o = inv_q;

    // Taps of output bit 0 over the 32-bit string
    localparam logic [STR_W-1:0] BIT0_TAPS = 32'hD0AD51C1;

    assert_bit0_taps_R3: assert property (@(posedge clk) disable iff (rst)
        gen_vld_i |=> crc_o[0] ==
            ~(^({$past(cid_i), $past(region_i), $past(type_i)} & BIT0_TAPS)));

    assert_marker_R4: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> (tag_o[7] && tag_o[6:0] == crc_o[6:0]));

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        gen_vld_i |=> res_vld_o);

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
        !gen_vld_i |=> !res_vld_o);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !gen_vld_i |=> ($stable(crc_o) && $stable(tag_o)));

    assert_invalidate_R7: assert property (@(posedge clk) disable iff (rst)
        inv_vld_i |=> (inv_vld_o && !inv_tag_o[7] &&
                       inv_tag_o[6:0] == $past(tag_i[6:0])));

    assert_inv_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !inv_vld_i |=> !inv_vld_o);

endmodule

// File: tb/crc8tag_gen_tb.sv
module crc8tag_gen_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 12;

    // {cid, region, type}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h000000_00, 32'hFFFFFF_FF, 32'h000001_00, 32'h800000_00,
        32'h123456_21, 32'hABCDEF_43, 32'h00FF00_2A, 32'h5A5A5A_4F,
        32'hDEADBE_20, 32'h000010_45, 32'hC0FFEE_77, 32'h7FFFFF_E3
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        gen_vld_i;
    logic [23:0] cid_i;
    logic [3:0]  region_i;
    logic [3:0]  type_i;
    logic        inv_vld_i;
    logic [7:0]  tag_i;
    logic        res_vld_o;
    logic [7:0]  crc_o;
    logic [7:0]  tag_o;
    logic        inv_vld_o;
    logic [7:0]  inv_tag_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc8tag_gen dut_i (
        .clk(clk), .rst(rst),
        .gen_vld_i(gen_vld_i), .cid_i(cid_i), .region_i(region_i), .type_i(type_i),
        .inv_vld_i(inv_vld_i), .tag_i(tag_i),
        .res_vld_o(res_vld_o), .crc_o(crc_o), .tag_o(tag_o),
        .inv_vld_o(inv_vld_o), .inv_tag_o(inv_tag_o)
    );

    // Reference: polynomial remainder of (0xFF*x^32 + s*x^8) modulo 0x107
    function automatic logic [7:0] ref_crc(input logic [31:0] s);
        logic [39:0] m;
        m = {8'hFF, 32'h0} ^ {s, 8'h0};
        for (int i = 39; i >= 8; i--) begin
            if (m[i]) m[i-:9] = m[i-:9] ^ 9'h107;
        end
        return m[7:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic gen(input logic [31:0] s);
        @(negedge clk);
        {cid_i, region_i, type_i} = s;
        gen_vld_i = 1'b1;
        @(negedge clk);
        gen_vld_i = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] c, held_crc, held_tag;
        rst = 1'b1; gen_vld_i = 1'b0; inv_vld_i = 1'b0;
        cid_i = '0; region_i = '0; type_i = '0; tag_i = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 crc", crc_o, 8'h00);
        check("R9 tag", tag_o, 8'h00);
        check("R9 vld", {6'b0, res_vld_o, inv_vld_o}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R9 after release", {res_vld_o, inv_vld_o, 6'b0} | crc_o | inv_tag_o, 8'h00);

        // R1 R2 R4 R5: vector table
        for (int k = 0; k < NVEC; k++) begin
            gen(VEC[k]);
            c = ref_crc(VEC[k]);
            check("R5 res_vld", {7'b0, res_vld_o}, 8'h01);
            check("R1 R2 crc", crc_o, c);
            check("R4 tag", tag_o, {1'b1, c[6:0]});
            // R3 bit 0 taps
            check("R3 bit0", {7'b0, crc_o[0]}, {7'b0, ~(^(VEC[k] & 32'hD0AD51C1))});
        end

        // R5 strobe drops after one cycle; R6 hold while inputs move
        held_crc = crc_o; held_tag = tag_o;
        cid_i = 24'h13579B; region_i = 4'h9; type_i = 4'h6;
        @(negedge clk);
        check("R5 vld low", {7'b0, res_vld_o}, 8'h00);
        check("R6 crc hold", crc_o, held_crc);
        check("R6 tag hold", tag_o, held_tag);

        // R10 aggregation regions
        for (int r = 0; r < 2; r++) begin
            logic [31:0] s;
            s = {24'h0A0B0C, (r == 0) ? 4'd2 : 4'd4, 4'h5};
            gen(s);
            c = ref_crc(s);
            check("R10 region tag", tag_o, {1'b1, c[6:0]});
        end

        // R7 invalidate
        held_crc = crc_o; held_tag = tag_o;
        @(negedge clk);
        tag_i = 8'hFF; inv_vld_i = 1'b1;
        @(negedge clk);
        inv_vld_i = 1'b0; tag_i = 8'hA5;
        check("R7 inv tag FF", inv_tag_o, 8'h7F);
        check("R7 inv vld", {7'b0, inv_vld_o}, 8'h01);
        // R8 generate side untouched
        check("R8 crc untouched", crc_o, held_crc);
        check("R8 tag untouched", tag_o, held_tag);
        check("R8 no res_vld", {7'b0, res_vld_o}, 8'h00);
        @(negedge clk);
        check("R7 inv vld low", {7'b0, inv_vld_o}, 8'h00);
        check("R7 inv hold", inv_tag_o, 8'h7F);
        tag_i = 8'h00; inv_vld_i = 1'b1;
        @(negedge clk);
        inv_vld_i = 1'b0;
        check("R7 inv tag 00", inv_tag_o, 8'h00);

        // R8 both strobes together
        @(negedge clk);
        {cid_i, region_i, type_i} = 32'h2468AC_41;
        tag_i = 8'hC3; gen_vld_i = 1'b1; inv_vld_i = 1'b1;
        @(negedge clk);
        gen_vld_i = 1'b0; inv_vld_i = 1'b0;
        c = ref_crc(32'h2468AC_41);
        check("R8 joint crc", crc_o, c);
        check("R8 joint inv", inv_tag_o, 8'h43);
        check("R8 joint vlds", {6'b0, res_vld_o, inv_vld_o}, 8'h03);

        // R9 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R9 midrun crc", crc_o, 8'h00);
        check("R9 midrun inv", inv_tag_o, 8'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule